// File: doc/BRIEF.md
# PC Card SRAM bus decoder

This block is the control and steering core of a battery-backed memory card. It sits between a 16-bit PC Card host bus and the card's memories. On the common-memory side there are pairs of byte-wide SRAM devices: one device in each pair holds the even bytes and the other holds the odd bytes. A byte-wide attribute store sits beside them. From the host strobes, the address and two board-level inputs, the block decides three things. It picks which device pair, bank and lane take part in the cycle. It picks whether the cycle is a read or a write. It picks which host lane each memory byte travels on.

All outputs are registered. A host pattern that is present at a rising clock edge appears on the outputs after that edge, so the latency is exactly one clock. The `isolate` input forces every host control to its inactive level, which is used while the card is being pulled from the socket. The `big_parts` input selects the address layout for the component size that is fitted: 1 = 4 Mbit devices, 0 = 1 Mbit devices. The wait output is tied inactive because the card never stretches a cycle.

Top module: `pcc_sram_decoder`

## Requirements
- R1: When both card enables (`ce_even_n`, `ce_odd_n`) are high, no pair select, bank strobe or attribute strobe is low, and both lane output enables are 0.
- R2: When `reg_n` is low, every bit of `pair_sel_n` and all four common bank strobes stay high. `attr_cs_n` is low whenever at least one card enable is low.
- R3: With `ce_even_n`=0, `ce_odd_n`=1 and A0=0, only the low bank is strobed, and data moves on lane bits [7:0]. The high lane enable is 0.
- R4: With `ce_even_n`=0, `ce_odd_n`=1 and A0=1, only the high bank is strobed. On a read, `host_rdata[7:0]` carries `hi_rdata`. On a write, `hi_wdata` takes `host_wdata[7:0]`. The high lane enable stays 0.
- R5: With `ce_even_n`=1 and `ce_odd_n`=0, only the high bank is strobed. Data moves on lane bits [15:8], with `hi_wdata` taken from `host_wdata[15:8]`, and the low lane enable is 0.
- R6: With both card enables low, both banks are strobed and both lanes are used. The even byte is on bits [7:0] and the odd byte is on bits [15:8].
- R7: With `big_parts`=0, the pair index is A20:A18 and drives exactly one low bit of `pair_sel_n`. `comp_addr` is A17:A1, zero-extended. `attr_addr` is A11:A1.
- R8: With `big_parts`=1, the pair index is A22:A20 and `comp_addr` is A19:A1. The values of A23 to A25 change no output.
- R9: The attribute store holds even bytes only. `attr_wr_n` goes low only for a write that includes the even byte. On an attribute read, any lane carrying an odd byte returns 8'hFF.
- R10: While `wp_sw` is 1, `lo_wr_n`, `hi_wr_n` and `attr_wr_n` all stay high, and `wp_flag` reads 1. While `wp_sw` is 0, writes are strobed normally.
- R11: While `isolate` is 1, the outputs match standby, whatever the host strobes do.
- R12: A read, meaning read strobes and lane output enables, happens only when `oe_n`=0 and `we_n`=1. When `we_n`=0 the cycle is a write and both lane output enables are 0.
- R13: `wait_n` is always 1.
- R14: Every output is registered. An input change becomes visible only after the next rising edge. While `rst_n` is low, all outputs sit at their standby values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_parts | input | 1 | 1 = 4 Mbit devices fitted, 0 = 1 Mbit devices |
| isolate | input | 1 | 1 forces all host controls inactive |
| wp_sw | input | 1 | Write-protect switch, 1 = protected |
| reg_n | input | 1 | Host space select, low = attribute store |
| ce_even_n | input | 1 | Host enable for the even byte |
| ce_odd_n | input | 1 | Host enable for the odd byte |
| oe_n | input | 1 | Host output enable |
| we_n | input | 1 | Host write enable |
| addr | input | 26 | Host byte address |
| host_wdata | input | 16 | Host write data, both lanes |
| lo_rdata | input | 8 | Read data from the even-byte bank |
| hi_rdata | input | 8 | Read data from the odd-byte bank |
| attr_rdata | input | 8 | Read data from the attribute store |
| pair_sel_n | output | 8 | Active-low device pair selects |
| comp_addr | output | 19 | Address inside one device |
| attr_addr | output | 11 | Attribute store address |
| lo_rd_n | output | 1 | Even bank read strobe |
| hi_rd_n | output | 1 | Odd bank read strobe |
| lo_wr_n | output | 1 | Even bank write strobe |
| hi_wr_n | output | 1 | Odd bank write strobe |
| attr_cs_n | output | 1 | Attribute store select |
| attr_rd_n | output | 1 | Attribute store read strobe |
| attr_wr_n | output | 1 | Attribute store write strobe |
| lo_wdata | output | 8 | Write data for the even bank and the attribute store |
| hi_wdata | output | 8 | Write data for the odd bank |
| host_rdata | output | 16 | Read data toward the host |
| lane_lo_oe | output | 1 | Drive enable for host bits [7:0] |
| lane_hi_oe | output | 1 | Drive enable for host bits [15:8] |
| wait_n | output | 1 | Cycle stretch request, always inactive |
| wp_flag | output | 1 | Registered write-protect state |

## Verification
Two functions can claim the same cycle: write-protect suppression and the rule that write enable overrides output enable. Both act on a cycle in which `we_n` and `oe_n` are both low. The bench sweeps every combination of space select, both enables, output enable, write enable and A0, once with the switch open and once with it closed. For each point it computes the expected strobes and lane routing from the requirements. A point where both functions fire is correct only if every write strobe stays high and both lane drivers are off at the same time, with no read strobe leaking through.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;

    // Kind of host cycle after the card enables and A0 are combined.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_EVEN,
        ACC_ODD_LOW,
        ACC_ODD_HIGH,
        ACC_WORD
    } acc_kind_t;

    // Qualified host intent, shared by the decode and steering stages.
    typedef struct packed {
        logic attr;     // attribute space
        logic rd;       // read cycle (output enable low, write enable high)
        logic wr;       // write cycle (write enable low)
        logic lo_act;   // even bank takes part
        logic hi_act;   // odd bank takes part
        logic swap;     // odd byte travels on the low lane
        logic lo_lane;  // host bits [7:0] carry data
        logic hi_lane;  // host bits [15:8] carry data
    } host_ctrl_t;

endpackage

// File: rtl/pcc_host_qual.sv
`timescale 1ns/1ps
module pcc_host_qual
    import pcc_pkg::*;
(
    input  logic       isolate,
    input  logic       reg_n,
    input  logic       ce_even_n,
    input  logic       ce_odd_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       a0,
    output acc_kind_t  kind,
    output host_ctrl_t ctrl
);

    logic reg_eff_n;
    logic cee_eff_n;
    logic ceo_eff_n;
    logic oe_eff_n;
    logic we_eff_n;

    // Isolation parks every host control at its inactive level.
    always_comb begin
        reg_eff_n = reg_n     | isolate;
        cee_eff_n = ce_even_n | isolate;
        ceo_eff_n = ce_odd_n  | isolate;
        oe_eff_n  = oe_n      | isolate;
        we_eff_n  = we_n      | isolate;
    end

    always_comb begin
        unique case ({cee_eff_n, ceo_eff_n})
            2'b00:   kind = ACC_WORD;
            2'b01:   kind = a0 ? ACC_ODD_LOW : ACC_EVEN;
            2'b10:   kind = ACC_ODD_HIGH;
            default: kind = ACC_IDLE;
        endcase
    end

    always_comb begin
        ctrl         = '0;
        ctrl.attr    = !reg_eff_n;
        ctrl.wr      = !we_eff_n;
        ctrl.rd      = !oe_eff_n && we_eff_n;
        ctrl.lo_act  = (kind == ACC_EVEN) || (kind == ACC_WORD);
        ctrl.hi_act  = (kind == ACC_ODD_LOW) || (kind == ACC_ODD_HIGH) || (kind == ACC_WORD);
        ctrl.swap    = (kind == ACC_ODD_LOW);
        ctrl.lo_lane = (kind == ACC_EVEN) || (kind == ACC_ODD_LOW) || (kind == ACC_WORD);
        ctrl.hi_lane = (kind == ACC_ODD_HIGH) || (kind == ACC_WORD);
    end

endmodule

// File: rtl/pcc_pair_decode.sv
`timescale 1ns/1ps
module pcc_pair_decode #(
    parameter int ADDR_W   = 26,
    parameter int NPAIR    = 8,
    parameter int SMALL_AW = 17,
    parameter int BIG_AW   = 19,
    parameter int ATTR_AW  = 11
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               big_parts,
    output logic [NPAIR-1:0]   pair_hit,
    output logic [BIG_AW-1:0]  comp_addr,
    output logic [ATTR_AW-1:0] attr_addr
);

    localparam int PAIR_W   = $clog2(NPAIR);
    localparam int SMALL_LO = SMALL_AW + 1;
    localparam int BIG_LO   = BIG_AW + 1;
    localparam int TOP_USED = BIG_LO + PAIR_W;

    logic [PAIR_W-1:0] pair_idx;
    logic              unused_addr_bits;

    // The pair field sits just above the in-device address; its position
    // moves with the component size.
    always_comb begin
        comp_addr = '0;
        if (big_parts) begin
            pair_idx  = addr[BIG_LO +: PAIR_W];
            comp_addr = addr[1 +: BIG_AW];
        end else begin
            pair_idx                = addr[SMALL_LO +: PAIR_W];
            comp_addr[SMALL_AW-1:0] = addr[1 +: SMALL_AW];
        end
        attr_addr = addr[1 +: ATTR_AW];
    end

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            assign pair_hit[p] = (pair_idx == PAIR_W'(p));
        end
    endgenerate

    // A0 is consumed by the lane logic; bits above the pair field are ignored.
    assign unused_addr_bits = ^{addr[ADDR_W-1:TOP_USED], addr[0]};

endmodule

// File: rtl/pcc_lane_steer.sv
`timescale 1ns/1ps
module pcc_lane_steer
    import pcc_pkg::*;
#(
    parameter int                LANE_W   = 8,
    parameter logic [LANE_W-1:0] ODD_FILL = '1
) (
    input  host_ctrl_t            ctrl,
    input  logic [2*LANE_W-1:0]   host_wdata,
    input  logic [LANE_W-1:0]     lo_rdata,
    input  logic [LANE_W-1:0]     hi_rdata,
    input  logic [LANE_W-1:0]     attr_rdata,
    output logic [2*LANE_W-1:0]   host_rdata,
    output logic                  lane_lo_oe,
    output logic                  lane_hi_oe,
    output logic [LANE_W-1:0]     lo_wdata,
    output logic [LANE_W-1:0]     hi_wdata
);

    logic [LANE_W-1:0] even_src;
    logic [LANE_W-1:0] odd_src;

    // The attribute store has no odd half; odd bytes read as the fill value.
    always_comb begin
        even_src = ctrl.attr ? attr_rdata : lo_rdata;
        odd_src  = ctrl.attr ? ODD_FILL   : hi_rdata;
    end

    always_comb begin
        lane_lo_oe = ctrl.rd && ctrl.lo_lane;
        lane_hi_oe = ctrl.rd && ctrl.hi_lane;
        host_rdata = '0;
        if (lane_lo_oe) begin
            host_rdata[LANE_W-1:0] = ctrl.swap ? odd_src : even_src;
        end
        if (lane_hi_oe) begin
            host_rdata[2*LANE_W-1:LANE_W] = odd_src;
        end
    end

    // Odd byte written through the low lane is moved up to the odd bank.
    always_comb begin
        lo_wdata = host_wdata[LANE_W-1:0];
        hi_wdata = ctrl.swap ? host_wdata[LANE_W-1:0] : host_wdata[2*LANE_W-1:LANE_W];
    end

endmodule

// File: rtl/pcc_sram_decoder.sv
`timescale 1ns/1ps
module pcc_sram_decoder
    import pcc_pkg::*;
#(
    parameter int                ADDR_W   = 26,
    parameter int                NPAIR    = 8,
    parameter int                SMALL_AW = 17,
    parameter int                BIG_AW   = 19,
    parameter int                ATTR_AW  = 11,
    parameter int                LANE_W   = 8,
    parameter logic [LANE_W-1:0] ODD_FILL = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 big_parts,
    input  logic                 isolate,
    input  logic                 wp_sw,
    input  logic                 reg_n,
    input  logic                 ce_even_n,
    input  logic                 ce_odd_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [2*LANE_W-1:0]  host_wdata,
    input  logic [LANE_W-1:0]    lo_rdata,
    input  logic [LANE_W-1:0]    hi_rdata,
    input  logic [LANE_W-1:0]    attr_rdata,
    output logic [NPAIR-1:0]     pair_sel_n,
    output logic [BIG_AW-1:0]    comp_addr,
    output logic [ATTR_AW-1:0]   attr_addr,
    output logic                 lo_rd_n,
    output logic                 hi_rd_n,
    output logic                 lo_wr_n,
    output logic                 hi_wr_n,
    output logic                 attr_cs_n,
    output logic                 attr_rd_n,
    output logic                 attr_wr_n,
    output logic [LANE_W-1:0]    lo_wdata,
    output logic [LANE_W-1:0]    hi_wdata,
    output logic [2*LANE_W-1:0]  host_rdata,
    output logic                 lane_lo_oe,
    output logic                 lane_hi_oe,
    output logic                 wait_n,
    output logic                 wp_flag
);

    localparam int DATA_W = 2 * LANE_W;

    typedef struct packed {
        logic [NPAIR-1:0]   pair_sel_n;
        logic [BIG_AW-1:0]  comp_addr;
        logic [ATTR_AW-1:0] attr_addr;
        logic               lo_rd_n;
        logic               hi_rd_n;
        logic               lo_wr_n;
        logic               hi_wr_n;
        logic               attr_cs_n;
        logic               attr_rd_n;
        logic               attr_wr_n;
        logic [LANE_W-1:0]  lo_wdata;
        logic [LANE_W-1:0]  hi_wdata;
        logic [DATA_W-1:0]  host_rdata;
        logic               lane_lo_oe;
        logic               lane_hi_oe;
        logic               wp_flag;
    } outs_t;

    acc_kind_t          kind;
    host_ctrl_t         ctrl;
    logic [NPAIR-1:0]   pair_hit;
    logic [BIG_AW-1:0]  comp_addr_c;
    logic [ATTR_AW-1:0] attr_addr_c;
    logic [DATA_W-1:0]  host_rdata_c;
    logic               lane_lo_oe_c;
    logic               lane_hi_oe_c;
    logic [LANE_W-1:0]  lo_wdata_c;
    logic [LANE_W-1:0]  hi_wdata_c;
    logic               unused_kind;
    outs_t              out_d;
    outs_t              out_q;

    pcc_host_qual u_qual (
        .isolate   (isolate),
        .reg_n     (reg_n),
        .ce_even_n (ce_even_n),
        .ce_odd_n  (ce_odd_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .a0        (addr[0]),
        .kind      (kind),
        .ctrl      (ctrl)
    );

    pcc_pair_decode #(
        .ADDR_W   (ADDR_W),
        .NPAIR    (NPAIR),
        .SMALL_AW (SMALL_AW),
        .BIG_AW   (BIG_AW),
        .ATTR_AW  (ATTR_AW)
    ) u_dec (
        .addr      (addr),
        .big_parts (big_parts),
        .pair_hit  (pair_hit),
        .comp_addr (comp_addr_c),
        .attr_addr (attr_addr_c)
    );

    pcc_lane_steer #(
        .LANE_W   (LANE_W),
        .ODD_FILL (ODD_FILL)
    ) u_steer (
        .ctrl       (ctrl),
        .host_wdata (host_wdata),
        .lo_rdata   (lo_rdata),
        .hi_rdata   (hi_rdata),
        .attr_rdata (attr_rdata),
        .host_rdata (host_rdata_c),
        .lane_lo_oe (lane_lo_oe_c),
        .lane_hi_oe (lane_hi_oe_c),
        .lo_wdata   (lo_wdata_c),
        .hi_wdata   (hi_wdata_c)
    );

    assign unused_kind = ^kind;

    // Next-value logic: strobes for both spaces, gated by write protection.
    always_comb begin
        logic common;
        logic any_bank;
        logic wr_ok;
        common   = !ctrl.attr;
        any_bank = ctrl.lo_act || ctrl.hi_act;
        wr_ok    = ctrl.wr && !wp_sw;

        out_d            = '0;
        out_d.pair_sel_n = (common && any_bank) ? ~pair_hit : '1;
        out_d.comp_addr  = comp_addr_c;
        out_d.attr_addr  = attr_addr_c;
        out_d.lo_rd_n    = !(common && ctrl.rd && ctrl.lo_act);
        out_d.hi_rd_n    = !(common && ctrl.rd && ctrl.hi_act);
        out_d.lo_wr_n    = !(common && wr_ok && ctrl.lo_act);
        out_d.hi_wr_n    = !(common && wr_ok && ctrl.hi_act);
        out_d.attr_cs_n  = !(ctrl.attr && any_bank);
        out_d.attr_rd_n  = !(ctrl.attr && ctrl.rd && any_bank);
        out_d.attr_wr_n  = !(ctrl.attr && wr_ok && ctrl.lo_act);
        out_d.lo_wdata   = lo_wdata_c;
        out_d.hi_wdata   = hi_wdata_c;
        out_d.host_rdata = host_rdata_c;
        out_d.lane_lo_oe = lane_lo_oe_c;
        out_d.lane_hi_oe = lane_hi_oe_c;
        out_d.wp_flag    = wp_sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q            <= '0;
            out_q.pair_sel_n <= '1;
            out_q.lo_rd_n    <= 1'b1;
            out_q.hi_rd_n    <= 1'b1;
            out_q.lo_wr_n    <= 1'b1;
            out_q.hi_wr_n    <= 1'b1;
            out_q.attr_cs_n  <= 1'b1;
            out_q.attr_rd_n  <= 1'b1;
            out_q.attr_wr_n  <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign pair_sel_n = out_q.pair_sel_n;
    assign comp_addr  = out_q.comp_addr;
    assign attr_addr  = out_q.attr_addr;
    assign lo_rd_n    = out_q.lo_rd_n;
    assign hi_rd_n    = out_q.hi_rd_n;
    assign lo_wr_n    = out_q.lo_wr_n;
    assign hi_wr_n    = out_q.hi_wr_n;
    assign attr_cs_n  = out_q.attr_cs_n;
    assign attr_rd_n  = out_q.attr_rd_n;
    assign attr_wr_n  = out_q.attr_wr_n;
    assign lo_wdata   = out_q.lo_wdata;
    assign hi_wdata   = out_q.hi_wdata;
    assign host_rdata = out_q.host_rdata;
    assign lane_lo_oe = out_q.lane_lo_oe;
    assign lane_hi_oe = out_q.lane_hi_oe;
    assign wp_flag    = out_q.wp_flag;
    assign wait_n     = 1'b1;

    AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_even_n && ce_odd_n) |-> (&pair_sel_n && attr_cs_n && !lane_lo_oe && !lane_hi_oe)); // R1

    AST_ATTR_NO_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_cs_n |-> (&pair_sel_n && lo_rd_n && hi_rd_n && lo_wr_n && hi_wr_n)); // R2

    AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pair_sel_n)); // R7

    AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_flag |-> (lo_wr_n && hi_wr_n && attr_wr_n)); // R10

    AST_ISOLATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(isolate) |-> (&pair_sel_n && attr_cs_n && lo_wr_n && hi_wr_n && !lane_lo_oe && !lane_hi_oe)); // R11

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_wr_n && hi_wr_n && attr_wr_n) |-> (!lane_lo_oe && !lane_hi_oe && lo_rd_n && hi_rd_n)); // R12

endmodule

// File: tb/pcc_sram_decoder_tb.sv
`timescale 1ns/1ps
module pcc_sram_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_parts = 1'b0;
    logic        isolate = 1'b0;
    logic        wp_sw = 1'b0;
    logic        reg_n = 1'b1;
    logic        ce_even_n = 1'b1;
    logic        ce_odd_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [25:0] addr = '0;
    logic [15:0] host_wdata = 16'hB29D;
    logic [7:0]  lo_rdata = 8'h3C;
    logic [7:0]  hi_rdata = 8'hC3;
    logic [7:0]  attr_rdata = 8'h5A;

    logic [7:0]  pair_sel_n;
    logic [18:0] comp_addr;
    logic [10:0] attr_addr;
    logic        lo_rd_n, hi_rd_n, lo_wr_n, hi_wr_n;
    logic        attr_cs_n, attr_rd_n, attr_wr_n;
    logic [7:0]  lo_wdata, hi_wdata;
    logic [15:0] host_rdata;
    logic        lane_lo_oe, lane_hi_oe, wait_n, wp_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcc_sram_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .big_parts(big_parts), .isolate(isolate),
        .wp_sw(wp_sw), .reg_n(reg_n), .ce_even_n(ce_even_n), .ce_odd_n(ce_odd_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .host_wdata(host_wdata),
        .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .attr_rdata(attr_rdata),
        .pair_sel_n(pair_sel_n), .comp_addr(comp_addr), .attr_addr(attr_addr),
        .lo_rd_n(lo_rd_n), .hi_rd_n(hi_rd_n), .lo_wr_n(lo_wr_n), .hi_wr_n(hi_wr_n),
        .attr_cs_n(attr_cs_n), .attr_rd_n(attr_rd_n), .attr_wr_n(attr_wr_n),
        .lo_wdata(lo_wdata), .hi_wdata(hi_wdata), .host_rdata(host_rdata),
        .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe), .wait_n(wait_n),
        .wp_flag(wp_flag)
    );

    // Expected observation: 18 control bits, masked read lanes, masked write bytes.
    typedef struct packed {
        logic [17:0] ctl;
        logic [15:0] rd;
        logic [7:0]  lw;
        logic [7:0]  hw;
    } obs_t;

    typedef struct packed {
        obs_t        val;
        logic [15:0] rd_m;
        logic [7:0]  lw_m;
        logic [7:0]  hw_m;
    } exp_t;

    function automatic exp_t model(input logic rg, ce, co, oe, we, a0, wp, iso,
                                   input int pair, input logic [7:0] lr, hr, ar,
                                   input logic [15:0] wd);
        exp_t e;
        logic attr, rd, wr, ev, ol, oh, wo, lo_b, hi_b, lo_l, hi_l, any, wok;
        logic [7:0] ps, lo_v, hi_v;
        if (iso) begin
            rg = 1; ce = 1; co = 1; oe = 1; we = 1;
        end
        attr = !rg; rd = !oe && we; wr = !we; wok = wr && !wp;
        ev = !ce && co && !a0;  ol = !ce && co && a0;
        oh = ce && !co;         wo = !ce && !co;
        lo_b = ev || wo;        hi_b = ol || oh || wo;
        lo_l = ev || ol || wo;  hi_l = oh || wo;
        any = lo_b || hi_b;
        ps = (!attr && any) ? ~(8'(1) << pair) : 8'hFF;
        e = '0;
        e.val.ctl = {ps,
                     !(!attr && rd && lo_b), !(!attr && rd && hi_b),
                     !(!attr && wok && lo_b), !(!attr && wok && hi_b),
                     !(attr && any), !(attr && rd && any), !(attr && wok && lo_b),
                     rd && lo_l, rd && hi_l, wp};
        lo_v = ol ? (attr ? 8'hFF : hr) : (attr ? ar : lr);
        hi_v = attr ? 8'hFF : hr;
        e.rd_m = {{8{rd && hi_l}}, {8{rd && lo_l}}};
        e.val.rd = {hi_v, lo_v} & e.rd_m;
        e.lw_m = {8{(!attr && wok && lo_b) || (attr && wok && lo_b)}};
        e.val.lw = wd[7:0] & e.lw_m;
        e.hw_m = {8{!attr && wok && hi_b}};
        e.val.hw = (ol ? wd[7:0] : wd[15:8]) & e.hw_m;
        return e;
    endfunction

    function automatic obs_t actual(input exp_t e);
        obs_t a;
        a.ctl = {pair_sel_n, lo_rd_n, hi_rd_n, lo_wr_n, hi_wr_n,
                 attr_cs_n, attr_rd_n, attr_wr_n, lane_lo_oe, lane_hi_oe, wp_flag};
        a.rd = host_rdata & e.rd_m;
        a.lw = lo_wdata & e.lw_m;
        a.hw = hi_wdata & e.hw_m;
        return a;
    endfunction

    task automatic check_vec(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_obs(input string tag, input exp_t e);
        check_vec(tag, 64'(actual(e)), 64'(e.val));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_bus(input logic rg, ce, co, oe, we);
        reg_n = rg; ce_even_n = ce; ce_odd_n = co; oe_n = oe; we_n = we;
    endtask

    function automatic exp_t model_now(input int pair);
        return model(reg_n, ce_even_n, ce_odd_n, oe_n, we_n, addr[0], wp_sw, isolate,
                     pair, lo_rdata, hi_rdata, attr_rdata, host_wdata);
    endfunction

    // R14: standby values under reset even with an active host pattern.
    task automatic t_reset();
        rst_n = 1'b0;
        set_bus(1, 0, 0, 0, 1);
        step();
        check_obs("R14 reset idle", model(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        check_vec("R13 wait_n in reset", 64'(wait_n), 64'(1'b1));
        set_bus(1, 1, 1, 1, 1);
        step();
        rst_n = 1'b1;
        step();
    endtask

    // R14: one clock of latency from input to output.
    task automatic t_latency();
        addr = 26'(2 << 18);
        set_bus(1, 1, 1, 1, 1);
        step();
        set_bus(1, 0, 1, 0, 1);
        #2;
        check_obs("R14 no change before edge", model(1, 1, 1, 1, 1, 0, 0, 0, 2, 0, 0, 0, 0));
        step();
        check_obs("R14 R3 visible after edge", model_now(2));
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    // Every host strobe combination with A0, switch open and closed.
    task automatic t_truth_table();
        big_parts = 1'b0;
        for (int w = 0; w < 2; w++) begin
            for (int v = 0; v < 64; v++) begin
                string tag;
                exp_t e;
                logic [5:0] b = 6'(v);
                wp_sw = w[0];
                addr = 26'(3 << 18) | 26'(12'h777 << 1) | 26'(b[0]);
                lo_rdata = 8'(v * 7 + 1);
                hi_rdata = 8'(v * 13 + 2);
                attr_rdata = 8'(v * 5 + 3);
                host_wdata = 16'(v * 16'h0929 + 16'h1357);
                set_bus(b[5], b[4], b[3], b[2], b[1]);
                step();
                e = model_now(3);
                if (b[4] && b[3])           tag = "R1 standby";
                else if (!b[1] && w[0])     tag = "R10 protected write";
                else if (!b[1] && !b[2])    tag = "R12 write overrides oe";
                else if (!b[5] && (b[4] || b[0])) tag = "R9 attr odd byte";
                else if (!b[5])             tag = "R2 attr space";
                else if (!b[4] && !b[3])    tag = "R6 word";
                else if (b[4])              tag = "R5 odd lane";
                else if (b[0])              tag = "R4 transposed odd";
                else                        tag = "R3 even byte";
                check_obs($sformatf("%s combo=%0d wp=%0d", tag, v, w), e);
                check_vec("R13 wait_n", 64'(wait_n), 64'(1'b1));
            end
        end
        wp_sw = 1'b0;
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    // R4: odd byte through the low lane, read and write, distinct patterns.
    task automatic t_transpose();
        lo_rdata = 8'h11; hi_rdata = 8'hEE; host_wdata = 16'h4C2B;
        addr = 26'(1 << 18) | 26'd1;
        set_bus(1, 0, 1, 0, 1);
        step();
        check_vec("R4 read odd on low lane", 64'({lane_lo_oe, lane_hi_oe, host_rdata[7:0]}),
                  64'({1'b1, 1'b0, 8'hEE}));
        set_bus(1, 0, 1, 1, 0);
        step();
        check_vec("R4 write odd from low lane", 64'({lo_wr_n, hi_wr_n, hi_wdata}),
                  64'({1'b1, 1'b0, 8'h2B}));
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    // R7: small device layout.
    task automatic t_addr_small();
        big_parts = 1'b0;
        addr = (26'd7 << 23) | (26'd3 << 21) | (26'd5 << 18) | (26'h1ABCD << 1);
        set_bus(1, 0, 1, 0, 1);
        step();
        check_vec("R7 small pair select", 64'(pair_sel_n), 64'(8'hDF));
        check_vec("R7 small comp_addr", 64'(comp_addr), 64'({2'b00, 17'h1ABCD}));
        check_vec("R7 attr_addr", 64'(attr_addr), 64'(addr[11:1]));
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    // R8: large device layout; top three address bits ignored.
    task automatic t_addr_big();
        logic [63:0] first;
        big_parts = 1'b1;
        addr = (26'd7 << 23) | (26'd6 << 20) | (26'h5A5A5 << 1);
        set_bus(1, 0, 0, 0, 1);
        step();
        check_vec("R8 big pair select", 64'(pair_sel_n), 64'(8'hBF));
        check_vec("R8 big comp_addr", 64'(comp_addr), 64'(19'h5A5A5));
        first = 64'({pair_sel_n, comp_addr, attr_addr, host_rdata});
        addr[25:23] = 3'b000;
        step();
        check_vec("R8 upper bits ignored", 64'({pair_sel_n, comp_addr, attr_addr, host_rdata}), first);
        big_parts = 1'b0;
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    // R11: isolation overrides active strobes, then releases.
    task automatic t_isolate();
        addr = 26'(4 << 18);
        isolate = 1'b1;
        set_bus(1, 0, 0, 1, 0);
        step();
        check_obs("R11 isolated write", model(1, 1, 1, 1, 1, 0, 0, 0, 4, 0, 0, 0, 0));
        set_bus(0, 0, 0, 0, 1);
        step();
        check_obs("R11 isolated attr read", model(1, 1, 1, 1, 1, 0, 0, 0, 4, 0, 0, 0, 0));
        isolate = 1'b0;
        step();
        check_obs("R11 released R2", model_now(4));
        set_bus(1, 1, 1, 1, 1);
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_truth_table();
        t_transpose();
        t_addr_small();
        t_addr_big();
        t_isolate();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule